// File: doc/BRIEF.md
# RV32E Integer Execute Unit

This block runs the integer register-register and register-immediate instructions of the reduced 16-register RISC-V base, one instruction per clock. An instruction word comes in with a valid strobe. The block decodes it, reads two operands from its own 16 x 32-bit register file, computes the result and writes it to the destination register on the clock edge that accepts the instruction. Encodings it does not support, and register indices above x15, raise a one-cycle illegal flag and change no register.

A registered debug read port returns the contents of any register, so a test environment can observe the architectural state. The block has no fetch, program counter, branches, memory access or control registers. The instruction source is responsible for sequencing.

Top module: `rv32e_exec`

## Requirements
- R1: A synchronous reset clears all sixteen registers to zero.
- R2: Register x0 always reads as zero. A legal instruction with rd = 0 writes nothing and does not raise the illegal flag.
- R3: Opcode 0110011 with funct7 0000000 gives ADD (funct3 000), XOR (100), OR (110) and AND (111). Opcode 0110011 with funct7 0100000 and funct3 000 gives SUB (rs1 - rs2). Each writes a 32-bit result to rd.
- R4: Under opcode 0110011 and funct7 0000000, funct3 010 (SLT, signed) and funct3 011 (SLTU, unsigned) write 1 to rd when rs1 is less than rs2, and 0 otherwise.
- R5: Under opcode 0110011, SLL (funct7 0000000, funct3 001), SRL (0000000, 101) and SRA (0100000, 101) shift rs1 by the low 5 bits of rs2. SRA fills vacated bits with bit 31. SLL and SRL fill with zeros.
- R6: Opcode 0010011 with funct3 000, 100, 110 or 111 gives ADDI, XORI, ORI or ANDI. Each uses instr[31:20] sign-extended to 32 bits as the second operand.
- R7: Opcode 0010011 with funct3 010 is SLTI, a signed compare. Funct3 011 is SLTIU: it sign-extends the immediate and then compares the two values as unsigned numbers.
- R8: Under opcode 0010011, the shift amount comes from instr[24:20] and instr[31:25] selects the variant. 0000000 with funct3 001 is SLLI. 0000000 with funct3 101 is SRLI. 0100000 with funct3 101 is SRAI.
- R9: An instruction whose rd or rs1 field, or whose rs2 field under opcode 0110011, holds 16 or more raises the illegal flag and writes nothing. In an immediate instruction, bits 24:20 are immediate bits and are never treated as a register index.
- R10: Any other opcode, or any funct7/funct3 pair not listed above, raises the illegal flag for exactly one cycle and leaves every register unchanged.
- R11: While instr_valid is low, no register is written and the illegal flag stays low, whatever instr holds.
- R12: A result written on edge k appears on dbg_data after edge k+1. An instruction accepted on edge k+1 already reads the value written on edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Registered contents of the selected register |
| illegal | output | 1 | Pulses the cycle after an unsupported instruction is accepted |

## Verification
The assertions check, on every cycle, that no write ever targets x0, that nothing is written while the strobe is low, that the illegal flag is high only after an accepted instruction and never together with a write, and that compare results are 0 or 1 and arithmetic shifts keep the sign bit. Only the bench scenarios can show the arithmetic values themselves, the immediate sign extension, the unsigned compare against a sign-extended immediate, the shift-amount masking, and that rejected encodings leave registers unchanged. They also show the debug read latency and that dependent instructions can be issued back to back.

// File: rtl/exu_pkg.sv
package exu_pkg;
  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] F7_BASE  = 7'b0000000;
  localparam logic [6:0] F7_ALT   = 7'b0100000;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [31:0]     instr,
  output alu_op_e         op,
  output logic            use_imm,
  output logic [XLEN-1:0] imm,
  output logic [AW-1:0]   rd,
  output logic [AW-1:0]   rs1,
  output logic [AW-1:0]   rs2,
  output logic            legal
);
  logic [6:0] opcode, f7;
  logic [2:0] f3;
  logic [4:0] rd_f, rs1_f, rs2_f;
  logic       funct_ok, regs_ok;

  assign opcode = instr[6:0];
  assign rd_f   = instr[11:7];
  assign f3     = instr[14:12];
  assign rs1_f  = instr[19:15];
  assign rs2_f  = instr[24:20];
  assign f7     = instr[31:25];

  assign imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign rd  = rd_f[AW-1:0];
  assign rs1 = rs1_f[AW-1:0];
  assign rs2 = rs2_f[AW-1:0];

  always_comb begin
    op       = ALU_ADD;
    use_imm  = 1'b0;
    funct_ok = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        if (f7 == F7_BASE) begin
          funct_ok = 1'b1;
          case (f3)
            3'd0: op = ALU_ADD;
            3'd1: op = ALU_SLL;
            3'd2: op = ALU_SLT;
            3'd3: op = ALU_SLTU;
            3'd4: op = ALU_XOR;
            3'd5: op = ALU_SRL;
            3'd6: op = ALU_OR;
            default: op = ALU_AND;
          endcase
        end else if (f7 == F7_ALT) begin
          if (f3 == 3'd0) begin
            op = ALU_SUB; funct_ok = 1'b1;
          end else if (f3 == 3'd5) begin
            op = ALU_SRA; funct_ok = 1'b1;
          end
        end
      end
      OPC_IMM: begin
        use_imm = 1'b1;
        case (f3)
          3'd0: begin op = ALU_ADD;  funct_ok = 1'b1; end
          3'd2: begin op = ALU_SLT;  funct_ok = 1'b1; end
          3'd3: begin op = ALU_SLTU; funct_ok = 1'b1; end
          3'd4: begin op = ALU_XOR;  funct_ok = 1'b1; end
          3'd6: begin op = ALU_OR;   funct_ok = 1'b1; end
          3'd7: begin op = ALU_AND;  funct_ok = 1'b1; end
          3'd1: begin
            op = ALU_SLL;
            funct_ok = (f7 == F7_BASE);
          end
          default: begin
            if (f7 == F7_BASE) begin
              op = ALU_SRL; funct_ok = 1'b1;
            end else if (f7 == F7_ALT) begin
              op = ALU_SRA; funct_ok = 1'b1;
            end
          end
        endcase
      end
      default: funct_ok = 1'b0;
    endcase
  end

  always_comb begin
    regs_ok = (int'(rd_f) < NREG) && (int'(rs1_f) < NREG) &&
              (use_imm || (int'(rs2_f) < NREG));
    legal   = funct_ok && regs_ok;
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  res = a + b;
      ALU_SUB:  res = a - b;
      ALU_SLL:  res = a << shamt;
      ALU_SLT:  res = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: res = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  res = a ^ b;
      ALU_SRL:  res = a >> shamt;
      ALU_SRA:  res = $unsigned($signed(a) >>> shamt);
      ALU_OR:   res = a | b;
      ALU_AND:  res = a & b;
      default:  res = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_SLT || op == ALU_SLTU)
      assert_cmp_bool_R4: assert (res[XLEN-1:1] == '0);
    if (op == ALU_SRA)
      assert_sra_sign_R5: assert (res[XLEN-1] == a[XLEN-1]);
  end
endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra1,
  output logic [XLEN-1:0] rd1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd2,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_q
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_q <= '0;
    else     dbg_q <= (dbg_addr == '0) ? '0 : mem[dbg_addr];
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/rv32e_exec.sv
module rv32e_exec
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_data,
  output logic            illegal
);
  alu_op_e         op;
  logic            use_imm, legal, wr_en;
  logic [XLEN-1:0] imm, a_val, rs2_val, b_val, result;
  logic [AW-1:0]   rd, rs1, rs2;

  exu_decode #(.XLEN(XLEN), .NREG(NREG)) u_dec (
    .instr(instr), .op(op), .use_imm(use_imm), .imm(imm),
    .rd(rd), .rs1(rs1), .rs2(rs2), .legal(legal)
  );

  exu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(rd), .wdata(result),
    .ra1(rs1), .rd1(a_val), .ra2(rs2), .rd2(rs2_val),
    .dbg_addr(dbg_addr), .dbg_q(dbg_data)
  );

  assign b_val = use_imm ? imm : rs2_val;

  exu_alu #(.XLEN(XLEN)) u_alu (
    .op(op), .a(a_val), .b(b_val), .res(result)
  );

  assign wr_en = instr_valid && legal && (rd != '0);

  always_ff @(posedge clk) begin
    if (rst) illegal <= 1'b0;
    else     illegal <= instr_valid && !legal;
  end

  assert_no_x0_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (rd != '0));
  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !wr_en);
  assert_illegal_after_valid_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(instr_valid));
  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !illegal);
endmodule

// File: tb/rv32e_exec_bench.sv
`timescale 1ns/1ps
module rv32e_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic last_illegal;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rv32e_exec u_rv32e_exec (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .illegal(illegal)
  );

  function automatic logic [31:0] r_op(input logic [6:0] f7, input int rs2,
                                       input int rs1, input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction

  function automatic logic [31:0] i_op(input int imm, input int rs1,
                                       input logic [2:0] f3, input int rd);
    return {12'(imm), 5'(rs1), f3, 5'(rd), 7'b0010011};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exec(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
    last_illegal = illegal;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    @(negedge clk);
    dbg_addr = 4'(a);
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic expect_reg(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    check(tag, v, exp);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    exec(i_op(77, 0, 3'd0, 9));
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, v);
      check($sformatf("R1 reset x%0d", i), v, 32'h0);
    end
    check("R1 illegal low after reset", {31'b0, illegal}, 32'h0);
  endtask

  task automatic test_rr_arith();
    exec(i_op(5, 0, 3'd0, 1));
    exec(i_op(-3, 0, 3'd0, 2));
    exec(r_op(7'h00, 2, 1, 3'd0, 3));
    exec(r_op(7'h20, 2, 1, 3'd0, 4));
    exec(r_op(7'h00, 2, 1, 3'd4, 5));
    exec(r_op(7'h00, 2, 1, 3'd6, 6));
    exec(r_op(7'h00, 2, 1, 3'd7, 7));
    expect_reg("R3 ADD", 3, 32'h2);
    expect_reg("R3 SUB", 4, 32'h8);
    expect_reg("R3 XOR", 5, 32'hFFFF_FFF8);
    expect_reg("R3 OR", 6, 32'hFFFF_FFFD);
    expect_reg("R3 AND", 7, 32'h5);
  endtask

  task automatic test_compare();
    exec(r_op(7'h00, 1, 2, 3'd2, 8));
    exec(r_op(7'h00, 1, 2, 3'd3, 9));
    exec(r_op(7'h00, 2, 1, 3'd2, 10));
    exec(r_op(7'h00, 2, 1, 3'd3, 11));
    expect_reg("R4 SLT -3<5", 8, 32'h1);
    expect_reg("R4 SLTU big<5", 9, 32'h0);
    expect_reg("R4 SLT 5<-3", 10, 32'h0);
    expect_reg("R4 SLTU 5<big", 11, 32'h1);
  endtask

  task automatic test_rr_shift();
    exec(i_op(35, 0, 3'd0, 12));
    exec(r_op(7'h00, 12, 1, 3'd1, 13));
    exec(r_op(7'h00, 12, 2, 3'd5, 14));
    exec(r_op(7'h20, 12, 2, 3'd5, 15));
    expect_reg("R5 SLL masked amount", 13, 32'd40);
    expect_reg("R5 SRL zero fill", 14, 32'h1FFF_FFFF);
    expect_reg("R5 SRA sign fill", 15, 32'hFFFF_FFFF);
  endtask

  task automatic test_imm_arith();
    exec(i_op(-6, 1, 3'd0, 3));
    exec(i_op(12'h7FF, 1, 3'd4, 4));
    exec(i_op(-16, 1, 3'd6, 5));
    exec(i_op(12'h0F0, 2, 3'd7, 6));
    expect_reg("R6 ADDI negative", 3, 32'hFFFF_FFFF);
    expect_reg("R6 XORI", 4, 32'h0000_07FA);
    expect_reg("R6 ORI sign-extended", 5, 32'hFFFF_FFF5);
    expect_reg("R6 ANDI", 6, 32'h0000_00F0);
  endtask

  task automatic test_imm_compare();
    exec(i_op(-2, 2, 3'd2, 7));
    exec(i_op(-1, 1, 3'd3, 8));
    exec(i_op(5, 2, 3'd3, 9));
    exec(i_op(4, 1, 3'd2, 10));
    expect_reg("R7 SLTI -3<-2", 7, 32'h1);
    expect_reg("R7 SLTIU 5<0xFFFFFFFF", 8, 32'h1);
    expect_reg("R7 SLTIU big<5", 9, 32'h0);
    expect_reg("R7 SLTI 5<4", 10, 32'h0);
  endtask

  task automatic test_imm_shift();
    exec(i_op(31, 1, 3'd1, 11));
    exec(i_op(12'h404, 11, 3'd5, 12));
    exec(i_op(4, 11, 3'd5, 13));
    expect_reg("R8 SLLI 31", 11, 32'h8000_0000);
    expect_reg("R8 SRAI 4", 12, 32'hF800_0000);
    expect_reg("R8 SRLI 4", 13, 32'h0800_0000);
  endtask

  task automatic test_x0();
    exec(i_op(5, 1, 3'd0, 0));
    check("R2 x0 write not illegal", {31'b0, last_illegal}, 32'h0);
    expect_reg("R2 x0 stays zero", 0, 32'h0);
    exec(r_op(7'h00, 1, 0, 3'd0, 14));
    expect_reg("R2 x0 as operand", 14, 32'h5);
  endtask

  task automatic test_bad_regs();
    exec(i_op(99, 0, 3'd0, 17));
    check("R9 rd=17 illegal", {31'b0, last_illegal}, 32'h1);
    expect_reg("R9 rd=17 no write to x1", 1, 32'h5);
    exec(r_op(7'h00, 1, 20, 3'd0, 3));
    check("R9 rs1=20 illegal", {31'b0, last_illegal}, 32'h1);
    exec(r_op(7'h00, 18, 1, 3'd0, 3));
    check("R9 rs2=18 illegal", {31'b0, last_illegal}, 32'h1);
    expect_reg("R9 x3 unchanged", 3, 32'hFFFF_FFFF);
    exec(i_op(16, 1, 3'd0, 15));
    check("R9 imm bits not a register", {31'b0, last_illegal}, 32'h0);
    expect_reg("R9 ADDI imm 16 into x15", 15, 32'd21);
  endtask

  task automatic test_bad_enc();
    exec({20'h12345, 5'd5, 7'b0110111});
    check("R10 unknown opcode illegal", {31'b0, last_illegal}, 32'h1);
    @(negedge clk);
    check("R10 flag lasts one cycle", {31'b0, illegal}, 32'h0);
    expect_reg("R10 x5 unchanged", 5, 32'hFFFF_FFF5);
    exec(r_op(7'h01, 2, 1, 3'd0, 6));
    check("R10 funct7 0000001 illegal", {31'b0, last_illegal}, 32'h1);
    exec(r_op(7'h20, 2, 1, 3'd1, 6));
    check("R10 alt funct7 with funct3 001", {31'b0, last_illegal}, 32'h1);
    exec(i_op(12'h403, 1, 3'd1, 6));
    check("R10 SLLI with alt funct7", {31'b0, last_illegal}, 32'h1);
    exec(i_op(12'h023, 1, 3'd5, 6));
    check("R10 SRLI with funct7 0000001", {31'b0, last_illegal}, 32'h1);
    expect_reg("R10 x6 unchanged", 6, 32'h0000_00F0);
  endtask

  task automatic test_idle();
    @(negedge clk);
    instr = i_op(123, 0, 3'd0, 7);
    instr_valid = 1'b0;
    @(negedge clk);
    check("R11 no flag while idle", {31'b0, illegal}, 32'h0);
    instr = {25'h0, 7'b1111111};
    @(negedge clk);
    check("R11 bad word while idle", {31'b0, illegal}, 32'h0);
    expect_reg("R11 x7 unchanged", 7, 32'h1);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    dbg_addr = 4'd1;
    instr_valid = 1'b1;
    instr = i_op(10, 0, 3'd0, 1);
    @(negedge clk);
    check("R12 old value one cycle after write", dbg_data, 32'h5);
    instr = i_op(1, 1, 3'd0, 1);
    @(negedge clk);
    check("R12 new value two cycles after write", dbg_data, 32'd10);
    instr = r_op(7'h00, 1, 1, 3'd0, 2);
    @(negedge clk);
    instr_valid = 1'b0;
    expect_reg("R12 dependent chain", 2, 32'd22);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_rr_arith();
    test_compare();
    test_rr_shift();
    test_imm_arith();
    test_imm_compare();
    test_imm_shift();
    test_x0();
    test_bad_regs();
    test_bad_enc();
    test_idle();
    test_back_to_back();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule